// File: doc/BRIEF.md
# Three-Wire Handshake Byte Transfer Controller

This block sits between a host processor and a peripheral-side packet engine. It moves packet bytes one at a time through an 8-bit shift-register value. Three active-low port-B lines pace the movement. The host drives two of them: one marks a transfer in progress and the other acknowledges each byte. The block drives the third, a request line, to tell the host that data is waiting or that a byte has been taken. Bytes move on changes of the host lines, not on a bit clock.

Two packet stores sit inside the block. The outbound store collects the bytes the host sends. When the host drops its in-progress line, the collected packet is handed to a consumer, which reads it through a read port. The inbound store is filled by the peripheral side and then committed with a length. From then on each byte is offered to the host in turn. Every handshake event schedules a shift-register interrupt to the host. The interrupt is raised after a fixed delay of DELAY_US microseconds, counted in clock cycles. A later event restarts that delay.

Top module: `hs_xfer_ctrl`

## Requirements
- R1: After reset, treq_n is high, sr_irq, sr_load_valid and pkt_out_valid are low, and both stores are empty, so idle port-B writes leave treq_n high.
- R2: Only bit 4 (acknowledge, active low) and bit 5 (in-progress, active low) of portb_wdata are examined. While in-progress is low, a port-B write moves a byte only if this pair differs from its value at the previous port-B write.
- R3: With in-progress low and dir_send high, each qualifying write stores sr_wdata into the next outbound slot. Once DEPTH bytes are held, further bytes are dropped without scheduling an interrupt.
- R4: A port-B write that raises in-progress after it was low delivers any collected bytes. pkt_out_valid pulses for one cycle with pkt_out_len, the bytes are readable at pkt_out_raddr, and the next packet starts again at slot 0.
- R5: With in-progress low and dir_send low, each qualifying write pulses sr_load_valid with the next unread inbound byte on sr_load_data. With no unread byte left, nothing is loaded.
- R6: The write that loads the last inbound byte drives treq_n high.
- R7: When in-progress was already high and stays high while acknowledge changes, treq_n takes the new acknowledge level and an interrupt is scheduled.
- R8: On an idle-side write with no acknowledge sync, treq_n is driven low while unread inbound bytes remain. treq_n changes on no cycle without a port-B write or a commit.
- R9: sr_irq is a one-cycle pulse, DELAY_US microseconds (DELAY_CYC cycles) after the most recent scheduling event. A new event restarts the count and cancels the pending pulse.
- R10: Raising in-progress after it was low always schedules an interrupt, even when no byte was collected.
- R11: pkt_commit sets the inbound size to pkt_len (capped at DEPTH), restarts reading at byte 0 and schedules an interrupt. If in-progress was high at the last write and pkt_len is non-zero, it drives treq_n low. A port-B write in the same cycle takes precedence and the commit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| portb_wr | input | 1 | Host write strobe for port B |
| portb_wdata | input | 8 | Port-B value written; bit 4 acknowledge, bit 5 in-progress |
| dir_send | input | 1 | Direction: 1 host sends, 0 host receives |
| sr_wdata | input | 8 | Shift-register value presented by the host |
| treq_n | output | 1 | Request line to host, active low |
| sr_load_valid | output | 1 | Pulse: an inbound byte is loaded into the shift register |
| sr_load_data | output | 8 | Inbound byte loaded |
| sr_irq | output | 1 | Delayed shift-register interrupt pulse |
| pkt_wr_en | input | 1 | Write enable for the inbound store |
| pkt_wr_addr | input | 4 | Inbound store write address |
| pkt_wr_data | input | 8 | Inbound store write data |
| pkt_commit | input | 1 | Commit the inbound packet |
| pkt_len | input | 5 | Length of the committed inbound packet |
| pkt_out_valid | output | 1 | Pulse: an outbound packet is complete |
| pkt_out_len | output | 5 | Length of the completed outbound packet |
| pkt_out_raddr | input | 4 | Outbound store read address |
| pkt_out_rdata | output | 8 | Outbound store read data, one cycle after the address |

## Verification
These results all appear one clock edge after the edge that samples the input: treq_n, sr_load_valid with its data, and pkt_out_valid with its length. sr_irq appears exactly DELAY_CYC edges after the scheduling edge. pkt_out_rdata follows its address by one edge. The bench drives inputs on the falling edge and advances a cycle-accurate reference state at each rising edge. It compares every output at the next falling edge, so a result that arrives one cycle early or late is reported. The interrupt-timing checks also count the idle cycles between an event and the first pulse.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

  // Port-B bit positions used by the handshake (active low lines)
  localparam int ACK_BIT = 4;
  localparam int TIP_BIT = 5;

  typedef struct packed {
    logic ack_n;
    logic tip_n;
  } hs_pair_t;

  // What a given cycle does to the transfer state
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_STORE,   // host-to-device byte captured
    ACT_LOAD,    // device-to-host byte offered
    ACT_SYNC,    // idle acknowledge toggle, request follows it
    ACT_FINISH,  // in-progress released
    ACT_IDLE,    // idle write without sync
    ACT_COMMIT   // new inbound packet
  } hs_act_e;

endpackage

// File: rtl/hsx_buf.sv
module hsx_buf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // Simple dual-port RAM with registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/hsx_delay.sv
module hsx_delay #(
  parameter int CYC = 1000,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse
);

  logic [CW-1:0] cnt_q;

  // Loaded on start, counts down; pulse when the last count expires.
  // A start in the expiring cycle restarts the wait and suppresses the pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= (cnt_q == CW'(1)) && !start;
      if (start)
        cnt_q <= CW'(CYC);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/hsx_ctrl.sv
module hsx_ctrl
  import hsx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          portb_wr,
  input  logic          ack_n,
  input  logic          tip_n,
  input  logic          dir_send,
  input  logic          pkt_commit,
  input  logic [IW-1:0] pkt_len,
  output logic          out_we,
  output logic [AW-1:0] out_waddr,
  output logic          in_re,
  output logic [AW-1:0] in_raddr,
  output logic          sched,
  output logic          treq_n,
  output logic          sr_load_valid,
  output logic          pkt_out_valid,
  output logic [IW-1:0] pkt_out_len
);

  hs_pair_t      last_q;
  logic [IW-1:0] out_idx_q;
  logic [IW-1:0] in_idx_q;
  logic [IW-1:0] in_size_q;
  hs_act_e       act;
  logic          pair_moved;
  logic          unread;
  logic [IW-1:0] in_idx_inc;
  logic [IW-1:0] len_capped;

  assign pair_moved = (ack_n != last_q.ack_n) || (tip_n != last_q.tip_n);
  assign unread     = in_idx_q < in_size_q;
  assign in_idx_inc = in_idx_q + IW'(1);
  assign len_capped = (pkt_len > IW'(DEPTH)) ? IW'(DEPTH) : pkt_len;

  // Classify the cycle; a port-B write wins over a commit
  always_comb begin
    act = ACT_NONE;
    if (portb_wr) begin
      if (!tip_n) begin
        if (dir_send) begin
          if (pair_moved && (out_idx_q < IW'(DEPTH))) act = ACT_STORE;
        end else begin
          if (pair_moved && unread) act = ACT_LOAD;
        end
      end else if (last_q.tip_n && (ack_n != last_q.ack_n)) begin
        act = ACT_SYNC;
      end else if (!last_q.tip_n) begin
        act = ACT_FINISH;
      end else begin
        act = ACT_IDLE;
      end
    end else if (pkt_commit) begin
      act = ACT_COMMIT;
    end
  end

  assign sched     = act inside {ACT_STORE, ACT_LOAD, ACT_SYNC, ACT_FINISH, ACT_COMMIT};
  assign out_we    = (act == ACT_STORE);
  assign out_waddr = out_idx_q[AW-1:0];
  assign in_re     = (act == ACT_LOAD);
  assign in_raddr  = in_idx_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q        <= '{ack_n: 1'b1, tip_n: 1'b1};
      out_idx_q     <= '0;
      in_idx_q      <= '0;
      in_size_q     <= '0;
      treq_n        <= 1'b1;
      sr_load_valid <= 1'b0;
      pkt_out_valid <= 1'b0;
      pkt_out_len   <= '0;
    end else begin
      sr_load_valid <= 1'b0;
      pkt_out_valid <= 1'b0;
      if (portb_wr) last_q <= '{ack_n: ack_n, tip_n: tip_n};
      case (act)
        ACT_STORE: out_idx_q <= out_idx_q + IW'(1);
        ACT_LOAD: begin
          in_idx_q      <= in_idx_inc;
          sr_load_valid <= 1'b1;
          if (in_idx_inc >= in_size_q) treq_n <= 1'b1;
        end
        ACT_SYNC: treq_n <= ack_n;
        ACT_FINISH: begin
          if (out_idx_q != '0) begin
            pkt_out_valid <= 1'b1;
            pkt_out_len   <= out_idx_q;
            out_idx_q     <= '0;
          end
          if (unread) treq_n <= 1'b0;
        end
        ACT_IDLE: if (unread) treq_n <= 1'b0;
        ACT_COMMIT: begin
          in_size_q <= len_capped;
          in_idx_q  <= '0;
          if (last_q.tip_n && (len_capped != '0)) treq_n <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/hs_xfer_ctrl.sv
module hs_xfer_ctrl
  import hsx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int CLK_HZ   = 50_000_000,
  parameter int DELAY_US = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       portb_wr,
  input  logic [7:0]                 portb_wdata,
  input  logic                       dir_send,
  input  logic [DW-1:0]              sr_wdata,
  output logic                       treq_n,
  output logic                       sr_load_valid,
  output logic [DW-1:0]              sr_load_data,
  output logic                       sr_irq,
  input  logic                       pkt_wr_en,
  input  logic [$clog2(DEPTH)-1:0]   pkt_wr_addr,
  input  logic [DW-1:0]              pkt_wr_data,
  input  logic                       pkt_commit,
  input  logic [$clog2(DEPTH+1)-1:0] pkt_len,
  output logic                       pkt_out_valid,
  output logic [$clog2(DEPTH+1)-1:0] pkt_out_len,
  input  logic [$clog2(DEPTH)-1:0]   pkt_out_raddr,
  output logic [DW-1:0]              pkt_out_rdata
);

  localparam int AW        = $clog2(DEPTH);
  localparam int DELAY_CYC = (CLK_HZ / 1_000_000) * DELAY_US;

  logic          out_we;
  logic [AW-1:0] out_waddr;
  logic          in_re;
  logic [AW-1:0] in_raddr;
  logic          sched;
  logic          unused_bits;

  assign unused_bits = ^{portb_wdata[7:6], portb_wdata[3:0]};

  hsx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .portb_wr     (portb_wr),
    .ack_n        (portb_wdata[ACK_BIT]),
    .tip_n        (portb_wdata[TIP_BIT]),
    .dir_send     (dir_send),
    .pkt_commit   (pkt_commit),
    .pkt_len      (pkt_len),
    .out_we       (out_we),
    .out_waddr    (out_waddr),
    .in_re        (in_re),
    .in_raddr     (in_raddr),
    .sched        (sched),
    .treq_n       (treq_n),
    .sr_load_valid(sr_load_valid),
    .pkt_out_valid(pkt_out_valid),
    .pkt_out_len  (pkt_out_len)
  );

  hsx_buf #(.DEPTH(DEPTH), .W(DW)) u_inbuf (
    .clk  (clk),
    .we   (pkt_wr_en),
    .waddr(pkt_wr_addr),
    .wdata(pkt_wr_data),
    .re   (in_re),
    .raddr(in_raddr),
    .rdata(sr_load_data)
  );

  hsx_buf #(.DEPTH(DEPTH), .W(DW)) u_outbuf (
    .clk  (clk),
    .we   (out_we),
    .waddr(out_waddr),
    .wdata(sr_wdata),
    .re   (1'b1),
    .raddr(pkt_out_raddr),
    .rdata(pkt_out_rdata)
  );

  hsx_delay #(.CYC(DELAY_CYC)) u_delay (
    .clk  (clk),
    .rst  (rst),
    .start(sched),
    .pulse(sr_irq)
  );

endmodule

// File: rtl/hsx_chk.sv
module hsx_chk #(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          portb_wr,
  input logic [7:0]    portb_wdata,
  input logic          dir_send,
  input logic          pkt_commit,
  input logic          treq_n,
  input logic          sr_irq,
  input logic          sr_load_valid,
  input logic          pkt_out_valid,
  input logic [IW-1:0] pkt_out_len
);

  logic seen_ack_n;
  logic seen_tip_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_ack_n <= 1'b1;
      seen_tip_n <= 1'b1;
    end else if (portb_wr) begin
      seen_ack_n <= portb_wdata[4];
      seen_tip_n <= portb_wdata[5];
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sr_irq |=> !sr_irq); // R9

  AST_LOAD_NEEDS_RECV: assert property (@(posedge clk) disable iff (rst)
    sr_load_valid |-> ($past(portb_wr) && !$past(portb_wdata[5]) && !$past(dir_send))); // R5

  AST_SAME_PAIR_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (portb_wr && portb_wdata[4] == seen_ack_n && portb_wdata[5] == seen_tip_n) |=> !sr_load_valid); // R2

  AST_DELIVER_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    pkt_out_valid |-> ($past(portb_wr) && $past(portb_wdata[5]))); // R4

  AST_DELIVER_LEN: assert property (@(posedge clk) disable iff (rst)
    pkt_out_valid |-> (pkt_out_len != '0 && pkt_out_len <= IW'(DEPTH))); // R3

  AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (portb_wr && portb_wdata[5] && seen_tip_n && portb_wdata[4] != seen_ack_n)
      |=> (treq_n == $past(portb_wdata[4]))); // R7

  AST_TREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!portb_wr && !pkt_commit) |=> $stable(treq_n)); // R8

endmodule

bind hs_xfer_ctrl hsx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .portb_wr     (portb_wr),
  .portb_wdata  (portb_wdata),
  .dir_send     (dir_send),
  .pkt_commit   (pkt_commit),
  .treq_n       (treq_n),
  .sr_irq       (sr_irq),
  .sr_load_valid(sr_load_valid),
  .pkt_out_valid(pkt_out_valid),
  .pkt_out_len  (pkt_out_len)
);

// File: tb/tb_hs_xfer_ctrl.sv
module tb_hs_xfer_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int DLY        = 20;   // 1 MHz clock, 20 us

  logic       clk = 1'b0;
  logic       rst;
  logic       portb_wr;
  logic [7:0] portb_wdata;
  logic       dir_send;
  logic [7:0] sr_wdata;
  logic       treq_n;
  logic       sr_load_valid;
  logic [7:0] sr_load_data;
  logic       sr_irq;
  logic       pkt_wr_en;
  logic [3:0] pkt_wr_addr;
  logic [7:0] pkt_wr_data;
  logic       pkt_commit;
  logic [4:0] pkt_len;
  logic       pkt_out_valid;
  logic [4:0] pkt_out_len;
  logic [3:0] pkt_out_raddr;
  logic [7:0] pkt_out_rdata;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hs_xfer_ctrl #(.DEPTH(DEPTH), .DW(8), .CLK_HZ(1_000_000), .DELAY_US(20)) dut (
    .clk(clk), .rst(rst), .portb_wr(portb_wr), .portb_wdata(portb_wdata),
    .dir_send(dir_send), .sr_wdata(sr_wdata), .treq_n(treq_n),
    .sr_load_valid(sr_load_valid), .sr_load_data(sr_load_data), .sr_irq(sr_irq),
    .pkt_wr_en(pkt_wr_en), .pkt_wr_addr(pkt_wr_addr), .pkt_wr_data(pkt_wr_data),
    .pkt_commit(pkt_commit), .pkt_len(pkt_len), .pkt_out_valid(pkt_out_valid),
    .pkt_out_len(pkt_out_len), .pkt_out_raddr(pkt_out_raddr),
    .pkt_out_rdata(pkt_out_rdata)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference state
  bit       r_ack, r_tip, r_treq;
  int       r_out_n, r_in_n, r_in_rd, r_cnt;
  bit [7:0] r_out [DEPTH];
  bit [7:0] r_in  [DEPTH];
  bit [7:0] r_pkt [DEPTH];
  bit       x_irq, x_load, x_dv;
  bit [7:0] x_ldata;
  int       x_dlen;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void ref_reset();
    r_ack = 1; r_tip = 1; r_treq = 1;
    r_out_n = 0; r_in_n = 0; r_in_rd = 0; r_cnt = 0;
    x_irq = 0; x_load = 0; x_dv = 0; x_dlen = 0; x_ldata = 0;
  endfunction

  // Advance the reference by one clock edge
  function automatic void ref_step(bit wr, bit a, bit t, bit d, bit [7:0] srw,
                                   bit cm, int len, bit pw, int pa, bit [7:0] pd);
    bit ev = 0;
    x_load = 0; x_dv = 0;
    if (wr) begin
      bit moved = (a != r_ack) || (t != r_tip);
      if (!t) begin
        if (d) begin
          if (moved && r_out_n < DEPTH) begin
            r_out[r_out_n] = srw; r_out_n++; ev = 1;
          end
        end else if (moved && r_in_rd < r_in_n) begin
          x_load = 1; x_ldata = r_in[r_in_rd]; r_in_rd++; ev = 1;
          if (r_in_rd == r_in_n) r_treq = 1;
        end
      end else if (r_tip && a != r_ack) begin
        r_treq = a; ev = 1;
      end else begin
        if (!r_tip) begin
          ev = 1;
          if (r_out_n > 0) begin
            x_dv = 1; x_dlen = r_out_n;
            for (int i = 0; i < DEPTH; i++) r_pkt[i] = r_out[i];
            r_out_n = 0;
          end
        end
        if (r_in_rd < r_in_n) r_treq = 0;
      end
      r_ack = a; r_tip = t;
    end else if (cm) begin
      r_in_n = (len > DEPTH) ? DEPTH : len;
      r_in_rd = 0; ev = 1;
      if (r_tip && r_in_n > 0) r_treq = 0;
    end
    if (pw) r_in[pa] = pd;
    x_irq = (r_cnt == 1) && !ev;
    if (ev) r_cnt = DLY;
    else if (r_cnt > 0) r_cnt--;
  endfunction

  task automatic cyc(bit wr, bit a, bit t, bit d, bit [7:0] srw,
                     bit cm, int len, bit pw, int pa, bit [7:0] pd);
    portb_wr    = wr;
    portb_wdata = {2'($urandom), t, a, 4'($urandom)};  // R2: junk in other bits
    dir_send    = d;
    sr_wdata    = srw;
    pkt_commit  = cm;
    pkt_len     = 5'(len);
    pkt_wr_en   = pw;
    pkt_wr_addr = 4'(pa);
    pkt_wr_data = pd;
    ref_step(wr, a, t, d, srw, cm, len, pw, pa, pd);
    @(posedge clk);
    @(negedge clk);
    chk("R8 treq_n (R6 R7 R11)", treq_n, r_treq);
    chk("R9 sr_irq", sr_irq, x_irq);
    chk("R5 sr_load_valid", sr_load_valid, x_load);
    if (x_load) chk("R5 sr_load_data", sr_load_data, x_ldata);
    chk("R4 pkt_out_valid", pkt_out_valid, x_dv);
    if (x_dv) chk("R4 pkt_out_len", pkt_out_len, x_dlen);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic pb(bit a, bit t, bit d, bit [7:0] srw);
    cyc(1, a, t, d, srw, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic fill_in(int n, bit [7:0] base);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00, 0, 0, 1, i, base + 8'(i));
  endtask

  task automatic commit(int n);
    cyc(0, 0, 0, 0, 8'h00, 1, n, 0, 0, 8'h00);
  endtask

  task automatic drain();
    for (int i = 0; i < DLY + 2; i++) idle();
  endtask

  // Count idle cycles until the first interrupt pulse
  task automatic irq_wait(output int k);
    k = -1;
    for (int i = 1; i <= DLY + 3; i++) begin
      idle();
      if (sr_irq && k < 0) k = i;
    end
  endtask

  task automatic read_out(int idx, bit [7:0] exp);
    pkt_out_raddr = 4'(idx);
    idle();
    chk("R4 pkt_out_rdata", pkt_out_rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    bit a;
    bit t;
    bit d;
    void'($urandom(32'd4711));
    rst = 1; portb_wr = 0; portb_wdata = 8'hFF; dir_send = 0; sr_wdata = 0;
    pkt_wr_en = 0; pkt_wr_addr = 0; pkt_wr_data = 0; pkt_commit = 0; pkt_len = 0;
    pkt_out_raddr = 0;
    ref_reset();
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 treq_n after reset", treq_n, 1);
    chk("R1 sr_irq after reset", sr_irq, 0);
    chk("R1 pkt_out_valid after reset", pkt_out_valid, 0);
    pb(1, 1, 0, 8'h00);
    pb(1, 1, 0, 8'h00);
    chk("R1 treq_n idle with empty store", treq_n, 1);

    // R3 R4 send of three bytes, with a repeated pair (R2)
    pb(1, 0, 1, 8'hA1);
    pb(0, 0, 1, 8'hA2);
    pb(1, 0, 1, 8'hA3);
    pb(1, 0, 1, 8'hEE);
    pb(1, 1, 1, 8'h00);
    chk("R4 delivery pulse", pkt_out_valid, 1);
    chk("R2 R4 length ignores repeated pair", pkt_out_len, 3);
    read_out(0, 8'hA1);
    read_out(1, 8'hA2);
    read_out(2, 8'hA3);
    drain();

    // R3 overflow: 18 edges keep only DEPTH bytes
    for (int i = 0; i < 18; i++) pb(i[0], 0, 1, 8'(8'h10 + i));
    pb(1, 1, 1, 8'h00);
    chk("R3 capped length", pkt_out_len, DEPTH);
    read_out(0, 8'h10);
    read_out(15, 8'h1F);
    drain();

    // R10 end with no byte still schedules interrupt
    pb(1, 0, 0, 8'h00);
    drain();
    pb(1, 1, 0, 8'h00);
    chk("R10 no delivery", pkt_out_valid, 0);
    irq_wait(k);
    chk("R10 R9 irq delay after empty end", k, DLY);

    // R11 R5 R6 receive
    fill_in(3, 8'hC0);
    commit(3);
    chk("R11 treq_n low on commit", treq_n, 0);
    irq_wait(k);
    chk("R11 irq after commit", k, DLY);
    pb(0, 0, 0, 8'h00);
    chk("R5 first byte", sr_load_data, 8'hC0);
    pb(1, 0, 0, 8'h00);
    pb(0, 0, 0, 8'h00);
    chk("R6 treq_n high after last byte", treq_n, 1);
    chk("R5 last byte", sr_load_data, 8'hC2);
    pb(1, 0, 0, 8'h00);
    chk("R5 nothing left to load", sr_load_valid, 0);
    pb(1, 1, 0, 8'h00);
    drain();

    // R7 sync on idle acknowledge toggles
    pb(0, 1, 0, 8'h00);
    chk("R7 treq_n follows ack low", treq_n, 0);
    pb(1, 1, 0, 8'h00);
    chk("R7 treq_n follows ack high", treq_n, 1);
    // R9 restart: second event after 10 cycles moves the pulse
    for (int i = 0; i < 10; i++) idle();
    pb(0, 1, 0, 8'h00);
    irq_wait(k);
    chk("R9 restarted delay", k, DLY);
    pb(1, 1, 0, 8'h00);
    drain();

    // R8 end of receive with bytes left drives request low
    fill_in(4, 8'h50);
    commit(4);
    pb(1, 0, 0, 8'h00);
    pb(0, 0, 0, 8'h00);
    pb(0, 1, 0, 8'h00);
    chk("R8 unread bytes keep request low", treq_n, 0);
    drain();

    // Random traffic checked against the reference every cycle
    d = 0; t = 1;
    for (int i = 0; i < 2500; i++) begin
      int op = $urandom % 20;
      if (op == 0) begin
        int n = $urandom % (DEPTH + 1);
        fill_in(n, 8'($urandom));
        commit(n);
      end else if (op < 4) begin
        idle();
      end else begin
        a = 1'($urandom);
        if ($urandom % 4 == 0) t = ~t;
        if ($urandom % 8 == 0) d = ~d;
        pb(a, t, d, 8'($urandom));
      end
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule